// File: doc/BRIEF.md
# Slow-Clock System Timer

This block is a memory-mapped system timer run from the main clock, with a one-cycle `tick_i` strobe standing for each edge of a 32768 Hz slow clock. It holds a free-running wrapping real-time counter behind a programmable prescaler, an alarm that fires when that counter lands on an absolute value, and a periodic interval timer that counts raw slow-clock ticks. Four event flags feed one status register, and a mask selects which of them drive the shared interrupt line.

Software programs the block through a simple single-cycle register port. The mask is changed through separate set and clear registers, so that bits not named in a write keep their value. Reading the status register returns the pending flags and clears them in the same access, which also drops the interrupt. Read data appears on `rdata_o` the cycle after the read strobe.

The register word addresses are: 0 prescaler, 1 alarm, 2 interval period, 3 mask set (write only), 4 mask clear (write only), 5 mask (read), 6 status (read and clear), 7 counter (read). Status bit positions are: bit 0 alarm, bit 1 interval, bit 2 counter advanced, bit 3 watchdog overflow.

Top module: `slow_sys_timer`

## Requirements
- R1: The real-time counter is CNT_W bits wide (20 by default), starts at 0, and wraps to 0 on the advance after its all-ones value.
- R2: The counter advances once every P ticks, where P is the prescaler register. The prescaler resets to 32768 (one advance per second). Writing 1 (or 0) makes it advance on every tick. Writing the prescaler restarts the tick count.
- R3: Each counter advance sets status bit 2.
- R4: Status bit 0 sets when the counter advances onto the alarm register value. An alarm written equal to the current count does not match until the counter has wrapped all the way round.
- R5: With a non-zero period N, status bit 1 sets once every N ticks. A period of 0 stops the interval timer. Writing the period register restarts the interval count from zero.
- R6: A one-cycle pulse on `wdog_ovf_i` sets status bit 3.
- R7: A read of address 6 returns the status flags on `rdata_o` and clears them. A flag raised in the same cycle as that read is kept and not lost.
- R8: A write to address 3 sets each mask bit written as 1. Zero bits leave the mask unchanged.
- R9: A write to address 4 clears each mask bit written as 1. Zero bits leave the mask unchanged.
- R10: `irq_o` is high while any status bit is set together with its mask bit, and it stays high until the status register is read.
- R11: After reset the registers read: prescaler 32768, alarm 0, period 0, mask 0, status 0, counter 0, and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle strobe per slow-clock period |
| wdog_ovf_i | input | 1 | Watchdog overflow event pulse |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | Register word address |
| wdata_i | input | DATA_W (20) | Write data |
| rdata_o | output | DATA_W (20) | Read data, valid the cycle after a read |
| irq_o | output | 1 | Shared timer interrupt |

## Verification
The checker watches on every cycle that the counter only ever steps by one modulo its width, that the alarm flag rises only with the counter equal to the alarm value, that mask bits rise only through the set register and fall only through the clear register, that status flags fall only through a status read, and that the interrupt never stands with the status empty. The prescaler ratio, the interval period and its restart, the delayed alarm after writing the current count, the full wrap, and a flag that arrives during a clearing read are shown only by the bench's scenarios, which read the registers back at the ports.

// File: rtl/sst_pkg.sv
package sst_pkg;
  typedef enum logic [2:0] {
    A_PRESC  = 3'd0,
    A_ALARM  = 3'd1,
    A_PERIOD = 3'd2,
    A_MSET   = 3'd3,
    A_MCLR   = 3'd4,
    A_MASK   = 3'd5,
    A_STAT   = 3'd6,
    A_COUNT  = 3'd7
  } reg_addr_e;

  localparam int unsigned NFLAG  = 4;
  localparam int unsigned F_ALM  = 0;
  localparam int unsigned F_PIT  = 1;
  localparam int unsigned F_INC  = 2;
  localparam int unsigned F_WDOG = 3;
endpackage

// File: rtl/sst_rtc.sv
module sst_rtc #(
  parameter int unsigned CNT_W   = 20,
  parameter int unsigned PRE_W   = 16,
  parameter int unsigned PRE_RST = 32768
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             pre_wr_i,
  input  logic [PRE_W-1:0] pre_val_i,
  input  logic             alm_wr_i,
  input  logic [CNT_W-1:0] alm_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [PRE_W-1:0] pre_o,
  output logic [CNT_W-1:0] alm_o,
  output logic             inc_o,
  output logic             match_o
);
  logic [PRE_W-1:0] pre_q, pre_cnt_q;
  logic [CNT_W-1:0] cnt_q, alm_q, cnt_nxt;
  logic             pre_done;

  // prescaler value 0 behaves as 1
  assign pre_done = ({1'b0, pre_cnt_q} + 1'b1) >= {1'b0, pre_q};
  assign inc_o    = tick_i && pre_done && !pre_wr_i;
  assign cnt_nxt  = cnt_q + 1'b1;
  assign match_o  = inc_o && (cnt_nxt == alm_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q     <= PRE_W'(PRE_RST);
      pre_cnt_q <= '0;
      cnt_q     <= '0;
    end else if (pre_wr_i) begin
      pre_q     <= pre_val_i;
      pre_cnt_q <= '0;
    end else if (tick_i) begin
      if (pre_done) begin
        pre_cnt_q <= '0;
        cnt_q     <= cnt_nxt;
      end else begin
        pre_cnt_q <= pre_cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       alm_q <= '0;
    else if (alm_wr_i) alm_q <= alm_val_i;
  end

  assign cnt_o = cnt_q;
  assign pre_o = pre_q;
  assign alm_o = alm_q;
endmodule

// File: rtl/sst_pit.sv
module sst_pit #(
  parameter int unsigned PIT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             per_wr_i,
  input  logic [PIT_W-1:0] per_val_i,
  output logic [PIT_W-1:0] per_o,
  output logic             fire_o
);
  logic [PIT_W-1:0] per_q, cnt_q;
  logic             done;

  assign done   = ({1'b0, cnt_q} + 1'b1) >= {1'b0, per_q};
  assign fire_o = tick_i && (per_q != '0) && done && !per_wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q <= '0;
      cnt_q <= '0;
    end else if (per_wr_i) begin
      per_q <= per_val_i;
      cnt_q <= '0;
    end else if (tick_i && per_q != '0) begin
      cnt_q <= done ? '0 : cnt_q + 1'b1;
    end
  end

  assign per_o = per_q;
endmodule

// File: rtl/sst_irq.sv
module sst_irq #(
  parameter int unsigned NF = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NF-1:0] set_i,
  input  logic          rd_clr_i,
  input  logic          mset_i,
  input  logic          mclr_i,
  input  logic [NF-1:0] wbits_i,
  output logic [NF-1:0] sts_o,
  output logic [NF-1:0] mask_o,
  output logic          irq_o
);
  logic [NF-1:0] sts_q, mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_q <= '0;
    else         sts_q <= (rd_clr_i ? '0 : sts_q) | set_i;  // new event beats clear
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     mask_q <= '0;
    else if (mset_i) mask_q <= mask_q | wbits_i;
    else if (mclr_i) mask_q <= mask_q & ~wbits_i;
  end

  assign sts_o  = sts_q;
  assign mask_o = mask_q;
  assign irq_o  = |(sts_q & mask_q);
endmodule

// File: rtl/slow_sys_timer.sv
module slow_sys_timer
  import sst_pkg::*;
#(
  parameter int unsigned CNT_W   = 20,
  parameter int unsigned PRE_W   = 16,
  parameter int unsigned PIT_W   = 16,
  parameter int unsigned PRE_RST = 32768,
  parameter int unsigned DATA_W  = CNT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wdog_ovf_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [2:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [CNT_W-1:0]  cnt, alm;
  logic [PRE_W-1:0]  pre;
  logic [PIT_W-1:0]  per;
  logic [NFLAG-1:0]  sts, mask, set;
  logic              inc, match, fire;
  logic              wr, rd;
  logic [DATA_W-1:0] rmux, rdata_q;

  assign wr = req_i && we_i;
  assign rd = req_i && !we_i;

  sst_rtc #(.CNT_W(CNT_W), .PRE_W(PRE_W), .PRE_RST(PRE_RST)) u_rtc (
    .clk_i, .rst_ni, .tick_i,
    .pre_wr_i  (wr && addr_i == A_PRESC),
    .pre_val_i (wdata_i[PRE_W-1:0]),
    .alm_wr_i  (wr && addr_i == A_ALARM),
    .alm_val_i (wdata_i[CNT_W-1:0]),
    .cnt_o     (cnt),
    .pre_o     (pre),
    .alm_o     (alm),
    .inc_o     (inc),
    .match_o   (match)
  );

  sst_pit #(.PIT_W(PIT_W)) u_pit (
    .clk_i, .rst_ni, .tick_i,
    .per_wr_i  (wr && addr_i == A_PERIOD),
    .per_val_i (wdata_i[PIT_W-1:0]),
    .per_o     (per),
    .fire_o    (fire)
  );

  always_comb begin
    set         = '0;
    set[F_ALM]  = match;
    set[F_PIT]  = fire;
    set[F_INC]  = inc;
    set[F_WDOG] = wdog_ovf_i;
  end

  sst_irq #(.NF(NFLAG)) u_irq (
    .clk_i, .rst_ni,
    .set_i    (set),
    .rd_clr_i (rd && addr_i == A_STAT),
    .mset_i   (wr && addr_i == A_MSET),
    .mclr_i   (wr && addr_i == A_MCLR),
    .wbits_i  (wdata_i[NFLAG-1:0]),
    .sts_o    (sts),
    .mask_o   (mask),
    .irq_o    (irq_o)
  );

  always_comb begin
    rmux = '0;
    unique case (addr_i)
      A_PRESC:  rmux = DATA_W'(pre);
      A_ALARM:  rmux = DATA_W'(alm);
      A_PERIOD: rmux = DATA_W'(per);
      A_MASK:   rmux = DATA_W'(mask);
      A_STAT:   rmux = DATA_W'(sts);
      A_COUNT:  rmux = DATA_W'(cnt);
      default:  rmux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (rd)  rdata_q <= rmux;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/sst_chk.sv
module sst_chk #(
  parameter int unsigned CNT_W = 20,
  parameter int unsigned NF    = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             we_i,
  input logic [2:0]       addr_i,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] alm,
  input logic [NF-1:0]    sts,
  input logic [NF-1:0]    mask,
  input logic             irq_o
);
  logic mset, mclr, rdst;
  assign mset = req_i && we_i && addr_i == 3'd3;
  assign mclr = req_i && we_i && addr_i == 3'd4;
  assign rdst = req_i && !we_i && addr_i == 3'd6;

  // R1
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cnt) |-> cnt == CNT_W'($past(cnt) + 1'b1));

  // R4
  alm_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sts[0]) |-> cnt == $past(alm));

  // R8
  mask_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(mask & ~$past(mask))) |-> $past(mset));

  // R9
  mask_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|($past(mask) & ~mask)) |-> $past(mclr));

  // R7
  sts_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|($past(sts) & ~sts)) |-> $past(rdst));

  // R10
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> sts != '0);
endmodule

bind slow_sys_timer sst_chk #(.CNT_W(CNT_W), .NF(sst_pkg::NFLAG)) u_chk (
  .clk_i, .rst_ni, .req_i, .we_i, .addr_i,
  .cnt(cnt), .alm(alm), .sts(sts), .mask(mask), .irq_o
);

// File: tb/sim_slow_sys_timer.sv
module sim_slow_sys_timer;
  localparam int unsigned CW = 10;  // narrow counter so a full wrap fits the run
  localparam int unsigned DW = CW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0, wdog = 1'b0;
  logic          req = 1'b0, we = 1'b0;
  logic [2:0]    addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          irq;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  slow_sys_timer #(.CNT_W(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wdog_ovf_i(wdog),
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq)
  );

  // kind: 0 write, 1 read+compare, 2 ticks (data = count), 3 irq compare
  typedef struct packed {
    logic [1:0]  kind;
    logic [2:0]  addr;
    logic [15:0] data;
    logic [15:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 43;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 3'd0, 16'd1,  16'd0,  4'd2},   // R2 prescaler 1
    '{2'd2, 3'd0, 16'd5,  16'd0,  4'd2},
    '{2'd1, 3'd7, 16'd0,  16'd5,  4'd2},   // R2 count 5
    '{2'd1, 3'd6, 16'd0,  16'd4,  4'd3},   // R3 advance flag
    '{2'd1, 3'd6, 16'd0,  16'd0,  4'd7},   // R7 cleared
    '{2'd0, 3'd1, 16'd8,  16'd0,  4'd4},
    '{2'd2, 3'd0, 16'd2,  16'd0,  4'd4},
    '{2'd1, 3'd6, 16'd0,  16'd4,  4'd4},   // R4 not yet
    '{2'd2, 3'd0, 16'd1,  16'd0,  4'd4},
    '{2'd1, 3'd6, 16'd0,  16'd5,  4'd4},   // R4 match at 8
    '{2'd0, 3'd1, 16'd8,  16'd0,  4'd4},   // R4 alarm = current
    '{2'd2, 3'd0, 16'd3,  16'd0,  4'd4},
    '{2'd1, 3'd6, 16'd0,  16'd4,  4'd4},
    '{2'd0, 3'd2, 16'd3,  16'd0,  4'd5},   // R5 period 3
    '{2'd2, 3'd0, 16'd2,  16'd0,  4'd5},
    '{2'd1, 3'd6, 16'd0,  16'd4,  4'd5},
    '{2'd2, 3'd0, 16'd1,  16'd0,  4'd5},
    '{2'd1, 3'd6, 16'd0,  16'd6,  4'd5},   // R5 fires
    '{2'd2, 3'd0, 16'd2,  16'd0,  4'd5},
    '{2'd0, 3'd2, 16'd3,  16'd0,  4'd5},   // R5 restart
    '{2'd2, 3'd0, 16'd2,  16'd0,  4'd5},
    '{2'd1, 3'd6, 16'd0,  16'd4,  4'd5},
    '{2'd2, 3'd0, 16'd1,  16'd0,  4'd5},
    '{2'd1, 3'd6, 16'd0,  16'd6,  4'd5},
    '{2'd0, 3'd3, 16'd3,  16'd0,  4'd8},   // R8 set 0011
    '{2'd1, 3'd5, 16'd0,  16'd3,  4'd8},
    '{2'd0, 3'd4, 16'd1,  16'd0,  4'd9},   // R9 clear 0001
    '{2'd1, 3'd5, 16'd0,  16'd2,  4'd9},
    '{2'd0, 3'd3, 16'd0,  16'd0,  4'd8},   // R8 zeros no effect
    '{2'd1, 3'd5, 16'd0,  16'd2,  4'd8},
    '{2'd0, 3'd4, 16'd0,  16'd0,  4'd9},   // R9 zeros no effect
    '{2'd1, 3'd5, 16'd0,  16'd2,  4'd9},
    '{2'd3, 3'd0, 16'd0,  16'd0,  4'd10},  // R10 idle
    '{2'd2, 3'd0, 16'd3,  16'd0,  4'd10},
    '{2'd3, 3'd0, 16'd0,  16'd1,  4'd10},  // R10 raised
    '{2'd2, 3'd0, 16'd1,  16'd0,  4'd10},
    '{2'd3, 3'd0, 16'd0,  16'd1,  4'd10},  // R10 held
    '{2'd1, 3'd6, 16'd0,  16'd6,  4'd10},
    '{2'd3, 3'd0, 16'd0,  16'd0,  4'd10},  // R10 dropped by read
    '{2'd0, 3'd2, 16'd0,  16'd0,  4'd5},   // R5 stop
    '{2'd2, 3'd0, 16'd5,  16'd0,  4'd5},
    '{2'd1, 3'd6, 16'd0,  16'd4,  4'd5},
    '{2'd1, 3'd7, 16'd0,  16'd28, 4'd1}    // R1 count so far
  };

  task automatic chk(input int r, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
    d = rdata;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin : wdog_timer
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [DW-1:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset values
    @(negedge clk);
    chk(11, DW'(irq), 0);
    rd_reg(3'd0, d); chk(11, d, DW'(32768 % (1 << DW)));
    rd_reg(3'd1, d); chk(11, d, 0);
    rd_reg(3'd2, d); chk(11, d, 0);
    rd_reg(3'd5, d); chk(11, d, 0);
    rd_reg(3'd6, d); chk(11, d, 0);
    rd_reg(3'd7, d); chk(11, d, 0);

    // R2 default prescaler: one advance per 32768 ticks
    ticks(32767);
    rd_reg(3'd7, d); chk(2, d, 0);
    ticks(1);
    rd_reg(3'd7, d); chk(2, d, 1);
    rd_reg(3'd6, d); chk(3, d, 4);

    do_reset();
    for (int i = 0; i < NV; i++) begin
      case (VEC[i].kind)
        2'd0: wr_reg(VEC[i].addr, DW'(VEC[i].data));
        2'd1: begin rd_reg(VEC[i].addr, d); chk(int'(VEC[i].req), d, DW'(VEC[i].exp)); end
        2'd2: ticks(int'(VEC[i].data));
        default: begin @(negedge clk); chk(int'(VEC[i].req), DW'(irq), DW'(VEC[i].exp)); end
      endcase
    end

    // R4 alarm written equal to count 28 waits a full wrap
    wr_reg(3'd1, 28);
    ticks((1 << CW) - 1);
    rd_reg(3'd7, d); chk(1, d, 27);
    rd_reg(3'd6, d); chk(4, d, 4);
    ticks(1);
    rd_reg(3'd6, d); chk(4, d, 5);
    // R1 wrap to zero
    ticks((1 << CW) - 28);
    rd_reg(3'd7, d); chk(1, d, 0);
    rd_reg(3'd6, d);

    // R6 watchdog flag
    @(negedge clk); wdog = 1'b1;
    @(negedge clk); wdog = 1'b0;
    rd_reg(3'd6, d); chk(6, d, 8);

    // R7 event in the same cycle as the clearing read is kept
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = 3'd6; wdog = 1'b1;
    @(negedge clk);
    req = 1'b0; wdog = 1'b0;
    chk(7, rdata, 0);
    rd_reg(3'd6, d); chk(7, d, 8);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule